// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block owns the single-wire command channel between a host controller and a memory card. Software-facing logic hands it a 32-bit argument and a command word; once the word's go bit is written, the engine assembles a 48-bit host-to-card frame with its 7-bit checksum. It then shifts the frame out one bit per card-clock enable pulse. If the command word asks for a reply, the engine releases the line, watches for the card's start bit, and captures either a short (48-bit) or a long (136-bit) reply into a 128-bit response store.

Control bits in the command word choose the reply type and whether the reply checksum is verified. They also select whether a wake-up preamble of idle-high clocks comes first, and whether the command must wait for a data transfer in progress elsewhere to drain. The outcome is posted as sticky bits in a raw interrupt vector that is cleared by writing ones. The data lines, block transfer, DMA and the card-clock divider sit outside this block; the engine only sees a one-cycle enable for each card-clock period.

Top module: `sdcmd_engine`

## Requirements
- R1: Writing `cmd_word` with bit 31 set while the engine is idle starts a command, and `cmd_go` reads 1 from the next clock until completion. A write made while `cmd_go` is 1 is ignored: no extra frame is ever sent.
- R2: The frame leaves MSB first with `cmd_oe` high, in this order: 0, 1, index (`cmd_word[5:0]`), argument, then CRC7 (x^7+x^3+1, register starting at zero) over the preceding 40 bits, then 1. For example, index 0 with argument 0 yields 48'h400000000095.
- R3: `cmd_out` and `cmd_oe` change only on clocks where `cclk_en` is 1, and each bit occupies exactly one enable period. When idle, `cmd_oe` is 0 and `cmd_out` is 1.
- R4: With `cmd_word[15]` set, exactly 80 enable periods of logic 1 with `cmd_oe` high precede the frame.
- R5: With `cmd_word[13]` set and `cmd_word[14]` clear, the frame does not start while `dat_busy` is 1. Setting `cmd_word[14]` removes this wait.
- R6: With `cmd_word[6]` set, the line is released after the end bit and a reply is captured: 136 bits if `cmd_word[7]` is set, 48 otherwise. A short reply stores its bits 39..8 in `resp_words[31:0]`; a long reply stores its bits 127..0 in `resp_words[127:0]`.
- R7: The reply's start bit (0 on `cmd_in`) must be sampled within the first 64 enable pulses after the release pulse. Otherwise `irq_raw[8]` and `irq_raw[2]` are set and `resp_words` is left unchanged.
- R8: With `cmd_word[8]` set, a CRC7 mismatch sets `irq_raw[6]`. The CRC covers reply bits 47..8 for a short reply and 127..8 for a long one, and is compared against bits 7..1. With `cmd_word[8]` clear, `irq_raw[6]` is never set.
- R9: A reply whose final bit is 0 sets `irq_raw[1]`.
- R10: Every command, including a failed one, sets `irq_raw[2]` on the same clock that `cmd_go` falls.
- R11: Bits of `irq_raw` are sticky and are cleared only by writing ones on `irq_clr`. Other bits keep their value.
- R12: A command with `cmd_word[6]` clear completes right after its end bit, sets only `irq_raw[2]`, and leaves `resp_words` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk_en | input | 1 | One-cycle pulse per card-clock period |
| cmd_wr | input | 1 | Write strobe for command word and argument |
| cmd_word | input | 32 | Command index and control bits |
| cmd_arg | input | 32 | Command argument |
| dat_busy | input | 1 | A data transfer is still in progress |
| irq_clr | input | 16 | Write-one-to-clear mask for the interrupt vector |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_go | output | 1 | Go bit readback; 1 while a command is in flight |
| irq_raw | output | 16 | Raw sticky interrupt status |
| resp_words | output | 128 | Four response words, word 0 in bits 31..0 |

## Verification
Frames are generated for several command indices and arguments. One of them is compared against a fixed all-zero reference, which separates a wrong polynomial or bit order from a merely self-consistent one. The wake-up preamble and the data-busy hold are each exercised to show that nothing is driven early.

Replies are fed in four forms: short with a good checksum, short with a bad checksum, long with good and bad checksums, and a bad final bit. The bad-checksum short reply is sent once with checking on and once with it off, which separates the check-enable path from the checksum itself. The start bit is placed on the 64th and the 65th enable pulse after release, which separates an off-by-one in the timeout window. A second write issued mid-frame shows whether busy writes leak into a new command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int RESP_W     = 128;
    localparam int IRQ_W      = 16;
    localparam int CRC_FLOOR  = 8;

    // command word bit positions
    localparam int CW_RESP    = 6;
    localparam int CW_LONG    = 7;
    localparam int CW_CRCCHK  = 8;
    localparam int CW_WAITDAT = 13;
    localparam int CW_STOP    = 14;
    localparam int CW_INIT    = 15;
    localparam int CW_GO      = 31;

    // raw interrupt bit positions
    localparam int IRQ_RESPERR = 1;
    localparam int IRQ_DONE    = 2;
    localparam int IRQ_RCRC    = 6;
    localparam int IRQ_RTO     = 8;

    typedef struct packed {
        logic       go;
        logic       init;
        logic       stop;
        logic       waitdat;
        logic       crcchk;
        logic       longr;
        logic       resp;
        logic [5:0] idx;
    } cmd_ctl_t;

    typedef struct packed {
        logic timed_out;
        logic crc_match;
        logic end_ok;
    } rx_result_t;

    typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_SEND, ST_RESP} eng_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_INIT, TX_FRAME} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_SHIFT} rx_state_t;

    function automatic cmd_ctl_t decode_cmd(input logic [31:0] w);
        cmd_ctl_t c;
        c.go      = w[CW_GO];
        c.init    = w[CW_INIT];
        c.stop    = w[CW_STOP];
        c.waitdat = w[CW_WAITDAT];
        c.crcchk  = w[CW_CRCCHK];
        c.longr   = w[CW_LONG];
        c.resp    = w[CW_RESP];
        c.idx     = w[5:0];
        return c;
    endfunction

    // serial CRC7 update, polynomial x^7 + x^3 + 1
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [5:0] idx,
                                                          input logic [31:0] arg);
        logic [39:0] body;
        logic [6:0]  c;
        body = {2'b01, idx, arg};
        c    = '0;
        for (int i = 39; i >= 0; i--) begin
            c = crc7_step(c, body[i]);
        end
        return {body, c, 1'b1};
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
#(
    parameter int INIT_TICKS = 80
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  launch,
    input  logic                  with_init,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  line_out,
    output logic                  line_oe,
    output logic                  released
);

    localparam int ICW = $clog2(INIT_TICKS + 1);
    localparam int BCW = $clog2(FRAME_BITS + 1);
    localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_TICKS - 1);
    localparam logic [BCW-1:0] BIT_END   = BCW'(FRAME_BITS);

    tx_state_t             st;
    logic [ICW-1:0]        icnt;
    logic [BCW-1:0]        bcnt;
    logic [FRAME_BITS-1:0] sh;

    assign released = tick && (st == TX_FRAME) && (bcnt == BIT_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TX_IDLE;
            icnt     <= '0;
            bcnt     <= '0;
            sh       <= '0;
            line_out <= 1'b1;
            line_oe  <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (launch) begin
                        sh   <= frame;
                        icnt <= '0;
                        bcnt <= '0;
                        st   <= with_init ? TX_INIT : TX_FRAME;
                    end
                end
                TX_INIT: begin
                    if (tick) begin
                        line_oe  <= 1'b1;
                        line_out <= 1'b1;
                        if (icnt == INIT_LAST) st <= TX_FRAME;
                        else                   icnt <= icnt + 1'b1;
                    end
                end
                TX_FRAME: begin
                    if (tick) begin
                        if (bcnt == BIT_END) begin
                            line_oe  <= 1'b0;
                            line_out <= 1'b1;
                            st       <= TX_IDLE;
                        end else begin
                            line_oe  <= 1'b1;
                            line_out <= sh[FRAME_BITS-1];
                            sh       <= {sh[FRAME_BITS-2:0], 1'b0};
                            bcnt     <= bcnt + 1'b1;
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    // R3: the line only moves on a card-clock enable
    p_line_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({line_oe, line_out}));

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 arm,
    input  logic                 long_sel,
    input  logic                 line_in,
    output logic                 done,
    output rx_result_t           result,
    output logic [LONG_BITS-1:0] bits
);

    localparam int CW = $clog2(LONG_BITS + 1);
    localparam int WW = $clog2(TMO_TICKS + 1);
    localparam logic [CW-1:0] LEN_S     = CW'(SHORT_BITS);
    localparam logic [CW-1:0] LEN_L     = CW'(LONG_BITS);
    localparam logic [CW-1:0] TOP_S     = CW'(SHORT_BITS - 1);
    localparam logic [CW-1:0] TOP_L     = CW'(RESP_W - 1);
    localparam logic [CW-1:0] CRC_LOW   = CW'(CRC_FLOOR);
    localparam logic [WW-1:0] WAIT_LAST = WW'(TMO_TICKS - 1);

    rx_state_t      st;
    logic           long_q;
    logic [CW-1:0]  cnt;
    logic [WW-1:0]  wcnt;
    logic [6:0]     crc;
    logic [CW-1:0]  len;
    logic [CW-1:0]  pos;
    logic [CW-1:0]  crc_top;
    logic           incl;
    logic           last;
    logic [6:0]     crc_nx;

    always_comb begin
        len     = long_q ? LEN_L : LEN_S;
        crc_top = long_q ? TOP_L : TOP_S;
        pos     = len - 1'b1 - cnt;
        incl    = (pos >= CRC_LOW) && (pos <= crc_top);
        last    = (cnt == len - 1'b1);
        crc_nx  = incl ? crc7_step(crc, line_in) : crc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            long_q <= 1'b0;
            cnt    <= '0;
            wcnt   <= '0;
            crc    <= '0;
            bits   <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (arm) begin
                        st     <= RX_WAIT;
                        long_q <= long_sel;
                        cnt    <= '0;
                        wcnt   <= '0;
                        crc    <= '0;
                    end
                end
                RX_WAIT: begin
                    if (tick) begin
                        if (!line_in) begin
                            bits <= {bits[LONG_BITS-2:0], line_in};
                            crc  <= crc_nx;
                            cnt  <= cnt + 1'b1;
                            st   <= RX_SHIFT;
                        end else if (wcnt == WAIT_LAST) begin
                            done             <= 1'b1;
                            result.timed_out <= 1'b1;
                            result.crc_match <= 1'b0;
                            result.end_ok    <= 1'b0;
                            st               <= RX_IDLE;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                RX_SHIFT: begin
                    if (tick) begin
                        bits <= {bits[LONG_BITS-2:0], line_in};
                        crc  <= crc_nx;
                        cnt  <= cnt + 1'b1;
                        if (last) begin
                            done             <= 1'b1;
                            result.timed_out <= 1'b0;
                            result.crc_match <= (crc == bits[6:0]);
                            result.end_ok    <= line_in;
                            st               <= RX_IDLE;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R6: a reply ends with a single completion pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int INIT_TICKS = 80,
    parameter int TMO_TICKS  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cclk_en,
    input  logic               cmd_wr,
    input  logic [31:0]        cmd_word,
    input  logic [31:0]        cmd_arg,
    input  logic               dat_busy,
    input  logic [IRQ_W-1:0]   irq_clr,
    input  logic               cmd_in,
    output logic               cmd_out,
    output logic               cmd_oe,
    output logic               cmd_go,
    output logic [IRQ_W-1:0]   irq_raw,
    output logic [RESP_W-1:0]  resp_words
);

    eng_state_t            state;
    logic [31:0]           cw_q;
    logic [31:0]           arg_q;
    cmd_ctl_t              ctl;
    logic [FRAME_BITS-1:0] frame;
    logic                  accept;
    logic                  hold_ok;
    logic                  tx_launch;
    logic                  tx_released;
    logic                  rx_arm;
    logic                  rx_done;
    rx_result_t            rx_res;
    logic [LONG_BITS-1:0]  rx_bits;
    logic                  finish_now;
    logic                  reply_end;
    logic [IRQ_W-1:0]      irq_set;

    always_comb begin
        ctl        = decode_cmd(cw_q);
        frame      = build_frame(ctl.idx, arg_q);
        accept     = (state == ST_IDLE) && cmd_wr && cmd_word[CW_GO];
        hold_ok    = !(ctl.waitdat && !ctl.stop && dat_busy);
        tx_launch  = (state == ST_HOLD) && hold_ok;
        rx_arm     = (state == ST_SEND) && tx_released && ctl.resp;
        reply_end  = (state == ST_RESP) && rx_done;
        finish_now = ((state == ST_SEND) && tx_released && !ctl.resp) || reply_end;
        irq_set    = '0;
        irq_set[IRQ_DONE] = finish_now;
        if (reply_end) begin
            irq_set[IRQ_RTO]     = rx_res.timed_out;
            irq_set[IRQ_RCRC]    = !rx_res.timed_out && ctl.crcchk && !rx_res.crc_match;
            irq_set[IRQ_RESPERR] = !rx_res.timed_out && !rx_res.end_ok;
        end
    end

    sdcmd_tx #(.INIT_TICKS(INIT_TICKS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (cclk_en),
        .launch    (tx_launch),
        .with_init (ctl.init),
        .frame     (frame),
        .line_out  (cmd_out),
        .line_oe   (cmd_oe),
        .released  (tx_released)
    );

    sdcmd_rx #(.TMO_TICKS(TMO_TICKS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (cclk_en),
        .arm      (rx_arm),
        .long_sel (ctl.longr),
        .line_in  (cmd_in),
        .done     (rx_done),
        .result   (rx_res),
        .bits     (rx_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cw_q       <= '0;
            arg_q      <= '0;
            cmd_go     <= 1'b0;
            irq_raw    <= '0;
            resp_words <= '0;
        end else begin
            irq_raw <= (irq_raw & ~irq_clr) | irq_set;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cw_q   <= cmd_word;
                        arg_q  <= cmd_arg;
                        cmd_go <= 1'b1;
                        state  <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (hold_ok) state <= ST_SEND;
                end
                ST_SEND: begin
                    if (tx_released) begin
                        if (ctl.resp) begin
                            state <= ST_RESP;
                        end else begin
                            cmd_go <= 1'b0;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_RESP: begin
                    if (rx_done) begin
                        cmd_go <= 1'b0;
                        state  <= ST_IDLE;
                        if (!rx_res.timed_out) begin
                            if (ctl.longr) resp_words <= rx_bits[RESP_W-1:0];
                            else           resp_words[31:0] <= rx_bits[39:8];
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: the line is only driven while a command is in flight
    p_drive_needs_go_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> cmd_go);

    // R5: a held command keeps the line released
    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && dat_busy && ctl.waitdat && !ctl.stop) |=> !cmd_oe);

    // R7: a timeout is always reported together with completion
    p_rto_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_raw[IRQ_RTO]) |-> irq_raw[IRQ_DONE]);

    // R10: the go bit falls only as completion is posted
    p_go_fall_done_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_go) |-> irq_raw[IRQ_DONE]);

endmodule

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         cclk_en;
    logic         cmd_wr;
    logic [31:0]  cmd_word;
    logic [31:0]  cmd_arg;
    logic         dat_busy;
    logic [15:0]  irq_clr;
    logic         cmd_in;
    logic         cmd_out;
    logic         cmd_oe;
    logic         cmd_go;
    logic [15:0]  irq_raw;
    logic [127:0] resp_words;

    int n_cmp = 0;
    int n_bad = 0;
    int stab_err = 0;
    logic last_oe, last_out;
    bit cap_q[$];
    logic [127:0] exp_resp;
    logic go_seen_mid;

    always #(CLK_P/2) clk = ~clk;

    sdcmd_engine uut (
        .clk(clk), .rst(rst), .cclk_en(cclk_en), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .cmd_arg(cmd_arg), .dat_busy(dat_busy),
        .irq_clr(irq_clr), .cmd_in(cmd_in), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .cmd_go(cmd_go), .irq_raw(irq_raw),
        .resp_words(resp_words)
    );

    // card clock enable: one pulse every four system clocks
    initial begin
        cclk_en = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            cclk_en <= 1'b1;
            @(negedge clk);
            cclk_en <= 1'b0;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, got=timeout exp=finish");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [135:0] got, input logic [135:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // reference CRC7 by polynomial long division over n message bits
    function automatic logic [6:0] ref_crc(input logic [127:0] msg, input int n);
        logic [134:0] v;
        logic [7:0]   g;
        v = '0;
        g = 8'h89;
        for (int i = 0; i < n; i++) v[i+7] = msg[i];
        for (int i = n + 6; i >= 7; i--) begin
            if (v[i]) begin
                for (int b = 0; b < 8; b++) v[i-7+b] = v[i-7+b] ^ g[b];
            end
        end
        return v[6:0];
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] m;
        m = {2'b01, idx, arg};
        return {m, ref_crc({88'd0, m}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] short_reply(input logic [5:0] idx, input logic [31:0] st,
                                                 input bit bad_crc, input bit bad_end);
        logic [39:0] m;
        logic [6:0]  c;
        m = {2'b00, idx, st};
        c = ref_crc({88'd0, m}, 40);
        if (bad_crc) c = c ^ 7'h10;
        return {88'd0, m, c, ~bad_end};
    endfunction

    function automatic logic [135:0] long_reply(input logic [119:0] body, input bit bad_crc);
        logic [6:0] c;
        c = ref_crc({8'd0, body}, 120);
        if (bad_crc) c = c ^ 7'h01;
        return {8'h3F, body, c, 1'b1};
    endfunction

    function automatic logic [47:0] cap_tail();
        logic [47:0] r;
        int s;
        r = '0;
        s = cap_q.size();
        if (s >= 48) for (int i = 0; i < 48; i++) r[47-i] = cap_q[s-48+i];
        return r;
    endfunction

    task automatic wait_tick();
        @(posedge clk);
        while (!cclk_en) begin
            @(negedge clk);
            if (cmd_oe !== last_oe || cmd_out !== last_out) stab_err++;
            @(posedge clk);
        end
        @(negedge clk);
        last_oe  = cmd_oe;
        last_out = cmd_out;
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] a);
        @(negedge clk);
        irq_clr = 16'hFFFF;
        @(negedge clk);
        irq_clr = 16'h0000;
        cmd_wr   = 1'b1;
        cmd_word = w;
        cmd_arg  = a;
        @(negedge clk);
        cmd_wr   = 1'b0;
        last_oe  = cmd_oe;
        last_out = cmd_out;
    endtask

    // delay: enable pulse after release on which the start bit is sampled (0 = silent card)
    task automatic run_cmd(input logic [31:0] w, input logic [31:0] a, input int delay,
                           input logic [135:0] reply, input int rlen,
                           input int busy_ticks, input bit poke);
        bit stayed;
        bit poked;
        cap_q.delete();
        go_seen_mid = 1'b0;
        poked = 1'b0;
        issue(w, a);
        if (busy_ticks > 0) begin
            stayed = 1'b1;
            for (int t = 0; t < busy_ticks; t++) begin
                wait_tick();
                if (cmd_oe !== 1'b0) stayed = 1'b0;
            end
            chk("R5 line quiet while data busy", {135'd0, stayed}, 136'd1);
            dat_busy = 1'b0;
        end
        for (int g = 0; g < 600; g++) begin
            wait_tick();
            if (cmd_oe === 1'b1) begin
                cap_q.push_back(cmd_out);
                if (poke && !poked && cap_q.size() == 10) begin
                    poked = 1'b1;
                    go_seen_mid = cmd_go;
                    cmd_wr   = 1'b1;
                    cmd_word = 32'h8000_8000 | 32'd5;
                    @(negedge clk);
                    cmd_wr   = 1'b0;
                end
            end else if (cap_q.size() > 0) begin
                break;
            end
        end
        if (delay > 0) begin
            for (int t = 1; t < delay; t++) begin
                cmd_in = 1'b1;
                wait_tick();
            end
            for (int j = rlen - 1; j >= 0; j--) begin
                cmd_in = reply[j];
                wait_tick();
            end
            cmd_in = 1'b1;
        end
        for (int i = 0; i < 3000 && irq_raw[2] !== 1'b1; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [135:0] rp;
        logic [119:0] body;
        rst = 1'b1; cmd_wr = 1'b0; cmd_word = '0; cmd_arg = '0;
        dat_busy = 1'b0; irq_clr = '0; cmd_in = 1'b1;
        exp_resp = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset idle line and status",
            {100'd0, cmd_oe, cmd_out, cmd_go, irq_raw}, {100'd0, 1'b0, 1'b1, 1'b0, 16'h0000});
        chk("R6 reset response store", {8'd0, resp_words}, 136'd0);

        // preamble + fixed reference frame, no reply
        run_cmd(32'h8000_8000, 32'h0, 0, '0, 0, 0, 1'b0);
        chk("R4 preamble+frame length", 136'(cap_q.size()), 136'd128);
        begin
            bit ones = 1'b1;
            for (int i = 0; i < 80; i++) if (cap_q[i] !== 1'b1) ones = 1'b0;
            chk("R4 preamble all ones", {135'd0, ones}, 136'd1);
        end
        chk("R2 fixed frame for index 0", {88'd0, cap_tail()}, {88'd0, 48'h400000000095});
        chk("R12 no-reply completion status", {120'd0, irq_raw}, 136'h0004);
        chk("R10 go cleared at completion", {135'd0, cmd_go}, 136'd0);
        chk("R12 response store untouched", {8'd0, resp_words}, {8'd0, exp_resp});

        // short reply, good CRC, plus a write attempted mid-frame
        rp = short_reply(6'd17, 32'hCAFE_0001, 1'b0, 1'b0);
        run_cmd(32'h8000_0151, 32'h1234_5678, 3, rp, 48, 0, 1'b1);
        chk("R1 go high during frame", {135'd0, go_seen_mid}, 136'd1);
        chk("R1 busy write sent nothing extra", 136'(cap_q.size()), 136'd48);
        chk("R2 frame index 17", {88'd0, cap_tail()}, {88'd0, ref_frame(6'd17, 32'h1234_5678)});
        chk("R8 good short reply status", {120'd0, irq_raw}, 136'h0004);
        exp_resp[31:0] = 32'hCAFE_0001;
        chk("R6 short reply word 0", {8'd0, resp_words}, {8'd0, exp_resp});
        repeat (200) @(negedge clk);
        chk("R1 ignored write never launched", {119'd0, cmd_go, irq_raw},
            {119'd0, 1'b0, 16'h0004});

        // short reply, bad CRC, check on
        rp = short_reply(6'd17, 32'h0BAD_0C7C, 1'b1, 1'b0);
        run_cmd(32'h8000_0151, 32'h0000_0001, 2, rp, 48, 0, 1'b0);
        chk("R8 bad CRC with check on", {120'd0, irq_raw}, 136'h0044);
        exp_resp[31:0] = 32'h0BAD_0C7C;

        // short reply, bad CRC, check off
        rp = short_reply(6'd17, 32'h7777_1111, 1'b1, 1'b0);
        run_cmd(32'h8000_0051, 32'h0000_0002, 2, rp, 48, 0, 1'b0);
        chk("R8 bad CRC with check off", {120'd0, irq_raw}, 136'h0004);
        exp_resp[31:0] = 32'h7777_1111;
        chk("R6 short reply with check off", {8'd0, resp_words}, {8'd0, exp_resp});

        // long reply, good CRC
        body = 120'h0123456789ABCDEFFEDCBA98765432;
        rp = long_reply(body, 1'b0);
        run_cmd(32'h8000_01C2, 32'h0, 5, rp, 136, 0, 1'b0);
        chk("R8 good long reply status", {120'd0, irq_raw}, 136'h0004);
        exp_resp = rp[127:0];
        chk("R6 long reply all words", {8'd0, resp_words}, {8'd0, exp_resp});

        // long reply, bad CRC
        rp = long_reply(~body, 1'b1);
        run_cmd(32'h8000_01C2, 32'h0, 4, rp, 136, 0, 1'b0);
        chk("R8 bad long CRC", {120'd0, irq_raw}, 136'h0044);
        exp_resp = rp[127:0];

        // bad end bit
        rp = short_reply(6'd17, 32'h5A5A_A5A5, 1'b0, 1'b1);
        run_cmd(32'h8000_0151, 32'h0, 3, rp, 48, 0, 1'b0);
        chk("R9 zero end bit", {120'd0, irq_raw}, 136'h0006);
        exp_resp[31:0] = 32'h5A5A_A5A5;

        // silent card
        run_cmd(32'h8000_0151, 32'h0, 0, '0, 0, 0, 1'b0);
        chk("R7 silent card timeout", {120'd0, irq_raw}, 136'h0104);
        chk("R7 response kept on timeout", {8'd0, resp_words}, {8'd0, exp_resp});
        @(negedge clk);
        irq_clr = 16'h0100;
        @(negedge clk);
        irq_clr = 16'h0000;
        @(negedge clk);
        chk("R11 selective clear", {120'd0, irq_raw}, 136'h0004);

        // start bit on the last allowed enable pulse
        rp = short_reply(6'd17, 32'h0000_0040, 1'b0, 1'b0);
        run_cmd(32'h8000_0151, 32'h0, 64, rp, 48, 0, 1'b0);
        chk("R7 start on pulse 64 accepted", {120'd0, irq_raw}, 136'h0004);
        exp_resp[31:0] = 32'h0000_0040;
        chk("R7 late-window reply stored", {8'd0, resp_words}, {8'd0, exp_resp});

        // start bit one pulse too late
        rp = short_reply(6'd17, 32'h0000_0041, 1'b0, 1'b0);
        run_cmd(32'h8000_0151, 32'h0, 65, rp, 48, 0, 1'b0);
        chk("R7 start on pulse 65 times out", {120'd0, irq_raw}, 136'h0104);
        chk("R7 late reply not stored", {8'd0, resp_words}, {8'd0, exp_resp});

        // wait for data transfer
        dat_busy = 1'b1;
        rp = short_reply(6'd17, 32'h0000_1234, 1'b0, 1'b0);
        run_cmd(32'h8000_2151, 32'hDEAD_BEEF, 3, rp, 48, 40, 1'b0);
        chk("R5 frame after data drained", {88'd0, cap_tail()},
            {88'd0, ref_frame(6'd17, 32'hDEAD_BEEF)});
        chk("R5 waited command completes", {120'd0, irq_raw}, 136'h0004);
        exp_resp[31:0] = 32'h0000_1234;

        // stop command bypasses the wait
        dat_busy = 1'b1;
        run_cmd(32'h8000_600C, 32'h0000_0000, 0, '0, 0, 0, 1'b0);
        chk("R5 stop overrides data wait", {88'd0, cap_tail()},
            {88'd0, ref_frame(6'd12, 32'h0)});
        chk("R5 stop completes while busy", {120'd0, irq_raw}, 136'h0004);
        dat_busy = 1'b0;
        @(negedge clk);
        irq_clr = 16'h0004;
        @(negedge clk);
        irq_clr = 16'h0000;
        @(negedge clk);
        chk("R11 clear done bit", {120'd0, irq_raw}, 136'h0000);

        chk("R3 line stable between enables", 136'(stab_err), 136'd0);
        summary();
        $finish;
    end

endmodule